// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block lets an I2C master read and write a bank of byte registers inside a device. It runs on the system clock and has no relation to any audio clock. SCL and SDA are brought into that clock domain through synchroniser flops, and start and stop conditions are recognised there. The target answers to the 7-bit address `1001 0 s1 s0`, which is 0x48 to 0x4B. The two low address bits come from two strap pins. Their values are captured once, when reset is released, and are held until the next reset. The block pulls SDA low through an open-drain enable to acknowledge bytes and to return read data.

On a write, the byte after the address sets an internal register pointer. Every later data byte produces a one-cycle write strobe at that pointer, and the pointer then steps up by one. On a read, bytes come from the pointer, MSB first, and the pointer steps up after each byte. A repeated start returns the target to the address phase and keeps the pointer. The usual way to read is therefore to write the pointer, send a repeated start, and then read.

Top module: `i2c_strap_target`

## Requirements
- R1: Start is a falling SDA while SCL is high, and it always begins a new address phase. Stop is a rising SDA while SCL is high. After a stop the target is idle and SDA is released one cycle after the stop is detected.
- R2: The target acknowledges an address byte whose upper 7 bits equal 1001 0, strap bit 1, strap bit 0. Bit 0 of the address byte selects the direction: 1 is read and 0 is write. The acknowledge is SDA held low during the 9th SCL clock. Any other address, for example 0x48 when the straps are 10, gets no acknowledge.
- R3: The straps are captured on the first clock after reset is released. A strap change after that has no effect on the address that is answered. A new reset captures the new strap values.
- R4: After an address that does not match, the target does not drive SDA and produces no write strobe until the next start or stop.
- R5: In a write, the first data byte loads the pointer and produces no strobe. Each later byte produces one strobe with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments by one. Every byte is acknowledged.
- R6: In a read, each byte is `reg_rdata` at the current pointer, sent MSB first. The pointer increments after each byte, including across separate transactions.
- R7: A master ACK (SDA low on the 9th clock) makes the target send the next byte. A master NACK leaves SDA released and ends driving until the next start.
- R8: A repeated start, including one in the middle of a byte, restarts the address phase and keeps the pointer. A partly received byte is discarded.
- R9: The target changes `sda_oe` only while SCL is low, so the data it drives is stable while SCL is high.
- R10: While reset is asserted, `sda_oe` and `reg_we` are 0. A write strobe is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line (wired-AND bus level) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel_i | input | 2 | Strap pins: bit 1 and bit 0 become address bits 1 and 0 |
| reg_addr | output | REG_AW | Register pointer, used for both read and write |
| reg_wdata | output | 8 | Write data for the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data of the register at `reg_addr`, returned combinationally |

## Verification
The assertions assume that bus changes are slow compared with the system clock. Each SCL low phase must last more than the synchroniser and edge-detect latency plus one cycle, so that the target's enable update falls inside that low phase. The assertions also assume that the master moves SDA only while SCL is low, except when it signals a start or a stop. The bench master holds each bus phase for ten system clocks. It changes its own SDA only a full phase after SCL falls, and it never issues a start or stop while the target could still be driving the line.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  // Fixed upper part of the 7-bit device address
  localparam logic [4:0] DEV_ADDR_UPPER = 5'b10010;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= RST_VAL;
        else        pipe_q <= line_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= pipe_q[STAGES-1];
  end

  assign level_o = pipe_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl,
  input  logic scl_prev,
  input  logic sda,
  input  logic sda_prev,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_held_high;

  always_comb begin
    scl_held_high = scl & scl_prev;
    start_o       = scl_held_high & sda_prev & ~sda;
    stop_o        = scl_held_high & ~sda_prev & sda;
    scl_rise_o    = scl & ~scl_prev;
    scl_fall_o    = ~scl & scl_prev;
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  tgt_state_e        state_q, state_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              full_q, full_d;
  logic              rw_q, rw_d;
  logic              more_q, more_d;
  logic [REG_AW-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    full_d  = full_q;
    rw_d    = rw_q;
    more_d  = more_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    we_d    = 1'b0;
    wdata_d = wdata_q;

    // pointer steps after each write strobe
    if (we_q) ptr_d = ptr_q + 1'b1;

    if (start) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      full_d  = 1'b0;
      oe_d    = 1'b0;
    end else if (stop) begin
      state_d = ST_IDLE;
      full_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            shift_d = {shift_q[BYTE_W-2:0], sda};
            bit_d   = bit_q + 1'b1;
            if (bit_q == 3'd7) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            bit_d  = '0;
            if (state_q == ST_ADDR) begin
              if (shift_q[7:1] == dev_addr) begin
                rw_d    = shift_q[0];
                oe_d    = 1'b1;
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_d   = shift_q[REG_AW-1:0];
              oe_d    = 1'b1;
              state_d = ST_PTR_ACK;
            end else begin
              we_d    = 1'b1;
              wdata_d = shift_q;
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d = ST_RD;
              shift_d = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              bit_d   = '0;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RD_ACK;
            end else begin
              bit_d   = bit_q + 1'b1;
              shift_d = {shift_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shift_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            more_d = ~sda;
          end else if (scl_fall) begin
            if (more_q) begin
              state_d = ST_RD;
              shift_d = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              bit_d   = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      more_q  <= 1'b0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      full_q  <= full_d;
      rw_q    <= rw_d;
      more_q  <= more_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel_i,
  output logic [REG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic [1:0] strap_q;
  logic       strap_lock;
  logic       scl_s, scl_p, sda_s, sda_p;
  logic       start_det, stop_det, scl_rise, scl_fall;
  logic [6:0] dev_addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // straps captured once after reset release
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      strap_q    <= '0;
      strap_lock <= 1'b0;
    end else if (!strap_lock) begin
      strap_q    <= addr_sel_i;
      strap_lock <= 1'b1;
    end
  end
  assign dev_addr = {DEV_ADDR_UPPER, strap_q};

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_sn), .line_i(scl_i), .level_o(scl_s), .prev_o(scl_p)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_sn), .line_i(sda_i), .level_o(sda_s), .prev_o(sda_p)
  );

  i2c_bus_events u_events (
    .scl(scl_s), .scl_prev(scl_p), .sda(sda_s), .sda_prev(sda_p),
    .start_o(start_det), .stop_o(stop_det),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  i2c_target_fsm #(.REG_AW(REG_AW)) u_fsm (
    .clk(clk), .rst_n(rst_sn),
    .start(start_det), .stop(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(sda_s),
    .dev_addr(dev_addr), .reg_rdata(reg_rdata),
    .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we)
  );
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
  parameter int unsigned REG_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              stop_det,
  input logic              strap_lock,
  input logic [1:0]        strap_q
);
  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_lock |=> $stable(strap_q));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == $past(reg_addr) + 1'b1));

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R10
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R10
  always_comb begin
    if (!rst_n) begin
      we_reset_chk: assert (!reg_we || $isunknown(reg_we));
    end
  end
endmodule

bind i2c_strap_target i2c_strap_target_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_addr(reg_addr), .stop_det(stop_det),
  .strap_lock(strap_lock), .strap_q(strap_q)
);

// File: tb/test_i2c_strap_target.sv
module test_i2c_strap_target;
  localparam int Q = 10;

  logic       clk;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_line;
  logic       sda_oe;
  logic [1:0] addr_sel;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;
  logic [7:0] mem [0:255];

  int    checks, failures;
  string phase_req;
  bit    done;
  bit    we_last;
  logic [15:0] exp_q [$];

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_strap_target i_i2c_strap_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_sel_i(addr_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the oldest expected write
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      // R10 strobe lasts one cycle
      chk(!we_last, "R10", "strobe length", 2, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, phase_req, "unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R5", "write addr/data",
            {reg_addr, reg_wdata}, e);
      end
    end
    we_last = rst_n && reg_we;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    logic first;
    sda_m = 1'b1; wq(); scl_m = 1'b1;
    repeat (Q / 2) @(negedge clk);
    first = sda_line;
    repeat (Q / 2) @(negedge clk);
    b = sda_line;
    // R9 line steady while SCL high
    chk(first == b, "R9", "sda moved during scl high", b, first);
    scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit exp_ack, input string req);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    chk(a == !exp_ack, req, "ack bit", a, !exp_ack);
  endtask

  task automatic rd_byte(input bit give_ack, input logic [7:0] exp, input string req);
    logic [7:0] d;
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!give_ack);
    chk(d == exp, req, "read data", d, exp);
  endtask

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic do_reset(input logic [1:0] strap);
    addr_sel = strap;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R10 idle outputs during reset
    chk(sda_oe == 1'b0, "R10", "sda_oe in reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R10", "reg_we in reset", reg_we, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0; we_last = 0;
    phase_req = "R4";
    scl_m = 1'b1; sda_m = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

    do_reset(2'b10);
    addr_sel = 2'b01; // R3 later strap change must be ignored

    // R2 R5 write with pointer and auto-increment
    phase_req = "R5";
    bus_start();
    wr_byte(8'h94, 1'b1, "R2");
    wr_byte(8'h10, 1'b1, "R5");
    push_wr(8'h10, 8'h11); wr_byte(8'h11, 1'b1, "R5");
    push_wr(8'h11, 8'h22); wr_byte(8'h22, 1'b1, "R5");
    push_wr(8'h12, 8'h33); wr_byte(8'h33, 1'b1, "R5");
    bus_stop();
    wq();
    chk(exp_q.size() == 0, "R5", "pending writes", exp_q.size(), 0);
    // R1 released after stop
    chk(sda_oe == 1'b0, "R1", "sda_oe after stop", sda_oe, 0);

    // R3 R4 address from new strap value is not answered, data ignored
    phase_req = "R4";
    bus_start();
    wr_byte(8'h92, 1'b0, "R3");
    wr_byte(8'h05, 1'b0, "R4");
    wr_byte(8'h77, 1'b0, "R4");
    bus_stop();
    // R2 other address in the range also rejected
    bus_start();
    wr_byte(8'h90, 1'b0, "R2");
    bus_stop();

    // R8 R6 R7 pointer write, repeated start, sequential read
    phase_req = "R8";
    bus_start();
    wr_byte(8'h94, 1'b1, "R2");
    wr_byte(8'h11, 1'b1, "R5");
    bus_rstart();
    wr_byte(8'h95, 1'b1, "R8");
    rd_byte(1'b1, 8'h22, "R6");
    rd_byte(1'b1, 8'h33, "R7");
    rd_byte(1'b0, 8'hB6, "R6");
    chk(sda_oe == 1'b0, "R7", "sda_oe after nack", sda_oe, 0);
    wq();
    chk(sda_oe == 1'b0, "R7", "sda_oe still released", sda_oe, 0);
    bus_stop();

    // R6 pointer persists across transactions
    bus_start();
    wr_byte(8'h95, 1'b1, "R2");
    rd_byte(1'b0, 8'hB1, "R6");
    bus_stop();

    // R8 repeated start inside a byte discards the partial byte
    bus_start();
    wr_byte(8'h94, 1'b1, "R2");
    wr_byte(8'h20, 1'b1, "R5");
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_rstart();
    wr_byte(8'h94, 1'b1, "R8");
    wr_byte(8'h30, 1'b1, "R8");
    push_wr(8'h30, 8'h5A); wr_byte(8'h5A, 1'b1, "R8");
    bus_stop();
    wq();
    chk(exp_q.size() == 0, "R8", "pending writes", exp_q.size(), 0);

    // R4 R1 mismatch recovers at the next start
    phase_req = "R4";
    bus_start();
    wr_byte(8'h92, 1'b0, "R4");
    bus_rstart();
    wr_byte(8'h94, 1'b1, "R1");
    wr_byte(8'h40, 1'b1, "R5");
    push_wr(8'h40, 8'hC3); wr_byte(8'hC3, 1'b1, "R1");
    bus_stop();
    wq();
    chk(exp_q.size() == 0, "R1", "pending writes", exp_q.size(), 0);

    // R3 new reset captures new straps
    do_reset(2'b11);
    bus_start();
    wr_byte(8'h96, 1'b1, "R3");
    bus_stop();
    bus_start();
    wr_byte(8'h94, 1'b0, "R3");
    bus_stop();
    wq();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule